// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block is a hardware master for a three-wire serial EEPROM. It fetches a single 16-bit word. The system asks for a read by pulsing a start input with a word address and a width select. The block then raises chip select and sends the three-bit read opcode `110` followed by the address on its serial data output, most significant bit first. Each bit is placed on the line while the serial clock is low, and the clock then rises on it. After the command, the block produces 16 more clock pulses and captures one returned bit per pulse, most significant bit first. It then drops chip select and pulses `done_o` with the assembled word on `word_o`.

The address field is 6 or 8 bits wide and is chosen per request with `wide_addr_i`, so the command is 9 or 11 bits long. In 6-bit mode the upper address bits are masked off. Each half of the serial clock lasts `HALF_PERIOD` system clocks.

Sequencer states:
- `ST_IDLE`: waiting.
- `ST_SELECT`: chip select up, clock low.
- `ST_CMD_LO` and `ST_CMD_HI`: the two halves of a command bit.
- `ST_DAT_LO` and `ST_DAT_HI`: the two halves of a data bit.
- `ST_FINISH`: chip select down, done pulse.

Transitions:
- start accepted: IDLE → SELECT.
- half-period tick: SELECT → CMD_LO, CMD_LO → CMD_HI, and DAT_LO → DAT_HI.
- at the end of CMD_HI: CMD_LO if command bits remain, otherwise DAT_LO.
- at the end of DAT_HI: DAT_LO if data bits remain, otherwise FINISH.
- always: FINISH → IDLE.

Top module: `eeprom_word_reader`

## Requirements
- R1: The command is opcode bits 1,1,0 followed by the address, all sent MSB first on `di_o`, one bit per rising edge of `sk_o`.
- R2: With `wide_addr_i`=1 the address is 8 bits and the command is 11 bits. With `wide_addr_i`=0 only `addr_i[5:0]` is sent and the command is 9 bits. A transaction therefore has 27 or 25 rising `sk_o` edges.
- R3: `cs_o` rises one full half period before the clock's first low half, so the first `sk_o` rise comes 2×HALF_PERIOD cycles after `cs_o` rises. `cs_o` stays high through every `sk_o` pulse of the transaction.
- R4: `di_o` changes only while `sk_o` is low. Every high phase of `sk_o` lasts exactly HALF_PERIOD system clocks.
- R5: After the command, 16 bits are taken from `sdi_i`, each at the end of an `sk_o` high phase, and assembled MSB first. `di_o` is low throughout the data phase.
- R6: `cs_o` falls in the cycle `done_o` is high. `done_o` is a one-cycle pulse. `word_o` shows the word from then on and holds it until the next word completes.
- R7: A start request while a transaction is in progress, including its done cycle, is ignored. The transfer in progress keeps its address, and no extra transfer follows.
- R8: `busy_o` rises in the cycle after an accepted start and falls in the cycle `done_o` pulses.
- R9: After reset `cs_o`, `sk_o`, `di_o`, `busy_o` and `done_o` are low and `word_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Read request, sampled when idle |
| wide_addr_i | input | 1 | 1: 8-bit address, 0: 6-bit address |
| addr_i | input | 8 | Word address |
| sdi_i | input | 1 | Serial data from the EEPROM |
| cs_o | output | 1 | Chip select to the EEPROM |
| sk_o | output | 1 | Serial clock to the EEPROM |
| di_o | output | 1 | Serial data to the EEPROM |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| word_o | output | 16 | Word read |

## Verification
A wrong bit counter or state shows up within one transaction as a wrong number of `sk_o` rises before `cs_o` falls. It also shows as a command the EEPROM model decodes to a different opcode or address, and hence as a wrong returned word. A divider fault is visible at the very first clock pulse as a high phase of the wrong length or a shifted chip-select lead. A lost busy guard shows when a second start arrives mid-transfer: the address changes or a second transfer follows.

// File: rtl/eewr_pkg.sv
package eewr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_CMD_LO,
        ST_CMD_HI,
        ST_DAT_LO,
        ST_DAT_HI,
        ST_FINISH
    } eewr_state_t;

    localparam logic [2:0] READ_OPCODE = 3'b110;
endpackage

// File: rtl/eewr_halfdiv.sv
module eewr_halfdiv #(
    parameter int HALF_PERIOD = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST) && !clr;

    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/eewr_cmd_shift.sv
module eewr_cmd_shift #(
    parameter int WIDE_AW   = 8,
    parameter int NARROW_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               wide,
    input  logic [WIDE_AW-1:0] addr,
    input  logic               shift,
    output logic               bit_o,
    output logic               last_o
);
    import eewr_pkg::*;

    localparam int OPC_W        = 3;
    localparam int CMD_W        = OPC_W + WIDE_AW;
    localparam int NARROW_CMD_W = OPC_W + NARROW_AW;
    localparam int PAD_W        = WIDE_AW - NARROW_AW;
    localparam int CW           = $clog2(CMD_W + 1);

    logic [CMD_W-1:0] sreg;
    logic [CW-1:0]    remain;

    assign bit_o  = sreg[CMD_W-1];
    assign last_o = (remain == CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg   <= '0;
            remain <= '0;
        end else if (load) begin
            if (wide) begin
                sreg   <= {READ_OPCODE, addr};
                remain <= CW'(CMD_W);
            end else begin
                sreg   <= {READ_OPCODE, addr[NARROW_AW-1:0], {PAD_W{1'b0}}};
                remain <= CW'(NARROW_CMD_W);
            end
        end else if (shift) begin
            sreg   <= {sreg[CMD_W-2:0], 1'b0};
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/eewr_rx_shift.sv
module eewr_rx_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic              sdi,
    output logic              last_o,
    output logic [DATA_W-1:0] word_o
);
    localparam int CW = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] sreg;
    logic [CW-1:0]     got;

    assign last_o = (got == CW'(DATA_W - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg   <= '0;
            got    <= '0;
            word_o <= '0;
        end else if (clear) begin
            sreg <= '0;
            got  <= '0;
        end else if (capture) begin
            sreg <= {sreg[DATA_W-2:0], sdi};
            got  <= got + 1'b1;
            if (last_o) begin
                word_o <= {sreg[DATA_W-2:0], sdi};
            end
        end
    end
endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader #(
    parameter int HALF_PERIOD = 1000,
    parameter int DATA_W      = 16,
    parameter int WIDE_AW     = 8,
    parameter int NARROW_AW   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              wide_addr_i,
    input  logic [WIDE_AW-1:0] addr_i,
    input  logic              sdi_i,
    output logic              cs_o,
    output logic              sk_o,
    output logic              di_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] word_o
);
    import eewr_pkg::*;

    localparam int WIDE_EDGES   = 3 + WIDE_AW + DATA_W;
    localparam int NARROW_EDGES = 3 + NARROW_AW + DATA_W;
    localparam int EW           = $clog2(WIDE_EDGES + 1);

    eewr_state_t state, nxt;

    logic tick;
    logic div_clr;
    logic accept;
    logic cmd_bit, cmd_last, cmd_shift;
    logic rx_last, rx_capture;

    assign accept     = (state == ST_IDLE) && start_i;
    assign div_clr    = (state == ST_IDLE) || (state == ST_FINISH);
    assign cmd_shift  = (state == ST_CMD_HI) && tick;
    assign rx_capture = (state == ST_DAT_HI) && tick;

    eewr_halfdiv #(.HALF_PERIOD(HALF_PERIOD)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (div_clr),
        .tick  (tick)
    );

    eewr_cmd_shift #(.WIDE_AW(WIDE_AW), .NARROW_AW(NARROW_AW)) u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .wide   (wide_addr_i),
        .addr   (addr_i),
        .shift  (cmd_shift),
        .bit_o  (cmd_bit),
        .last_o (cmd_last)
    );

    eewr_rx_shift #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (rx_capture),
        .sdi     (sdi_i),
        .last_o  (rx_last),
        .word_o  (word_o)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start_i) nxt = ST_SELECT;
            ST_SELECT: if (tick) nxt = ST_CMD_LO;
            ST_CMD_LO: if (tick) nxt = ST_CMD_HI;
            ST_CMD_HI: if (tick) nxt = cmd_last ? ST_DAT_LO : ST_CMD_LO;
            ST_DAT_LO: if (tick) nxt = ST_DAT_HI;
            ST_DAT_HI: if (tick) nxt = rx_last ? ST_FINISH : ST_DAT_LO;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cs_o   = 1'b0;
        sk_o   = 1'b0;
        di_o   = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_SELECT: begin cs_o = 1'b1; busy_o = 1'b1; end
            ST_CMD_LO: begin cs_o = 1'b1; busy_o = 1'b1; di_o = cmd_bit; end
            ST_CMD_HI: begin cs_o = 1'b1; busy_o = 1'b1; di_o = cmd_bit; sk_o = 1'b1; end
            ST_DAT_LO: begin cs_o = 1'b1; busy_o = 1'b1; end
            ST_DAT_HI: begin cs_o = 1'b1; busy_o = 1'b1; sk_o = 1'b1; end
            ST_FINISH: done_o = 1'b1;
            default:   ;
        endcase
    end

    // checker state: rising sk edges per transaction
    logic          sk_q;
    logic          wide_q;
    logic [EW-1:0] sk_edges;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_q     <= 1'b0;
            wide_q   <= 1'b0;
            sk_edges <= '0;
        end else begin
            sk_q <= sk_o;
            if (accept) begin
                wide_q   <= wide_addr_i;
                sk_edges <= '0;
            end else if (sk_o && !sk_q) begin
                sk_edges <= sk_edges + 1'b1;
            end
        end
    end

    a_r2_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sk_edges == (wide_q ? EW'(WIDE_EDGES) : EW'(NARROW_EDGES))));

    a_r3_cs_over_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sk_o) |-> (cs_o && $past(cs_o)));

    a_r4_di_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_o && $past(sk_o)) |-> $stable(di_o));

    a_r6_done_drops_cs: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!cs_o && $past(cs_o)));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
endmodule

// File: tb/eeprom_word_reader_tb.sv
module eeprom_word_reader_tb;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        wide_addr_i = 1'b1;
    logic [7:0]  addr_i = '0;
    logic        sdi_i = 1'b0;
    logic        cs_o, sk_o, di_o, busy_o, done_o;
    logic [15:0] word_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    eeprom_word_reader #(.HALF_PERIOD(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_addr_i(wide_addr_i),
        .addr_i(addr_i), .sdi_i(sdi_i), .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o),
        .busy_o(busy_o), .done_o(done_o), .word_o(word_o)
    );

    function automatic logic [15:0] rom(input logic [7:0] a);
        return {a ^ 8'h3C, ~a};
    endfunction

    // EEPROM model
    int          model_len = 11;
    int          nbits = 0;
    logic [10:0] rx_cmd = '0;
    logic [15:0] rom_word = '0;
    int          cs_err = 0;
    int          di_data_err = 0;

    always @(posedge sk_o or negedge cs_o) begin
        if (!cs_o) begin
            nbits  = 0;
            sdi_i  = 1'b0;
        end else begin
            if (nbits < model_len) begin
                rx_cmd = {rx_cmd[9:0], di_o};
                if (nbits == model_len - 1)
                    rom_word = (model_len == 11) ? rom(rx_cmd[7:0]) : rom({2'b00, rx_cmd[5:0]});
            end else begin
                if (di_o) di_data_err++;
                if (nbits - model_len < 16) sdi_i = rom_word[15 - (nbits - model_len)];
            end
            nbits++;
        end
    end

    // line monitor
    logic prev_sk = 0, prev_di = 0, seen = 0;
    int   hi_len = 0, per_bad = 0, stab_bad = 0, lead = 0, lead_meas = 0, sk_rises = 0;

    always @(negedge clk) begin
        cycles++;
        if (sk_o && prev_sk && di_o != prev_di) stab_bad++;
        if (sk_o) hi_len++;
        if (!sk_o && prev_sk) begin
            if (hi_len != HALF) per_bad++;
            hi_len = 0;
        end
        if (sk_o && !prev_sk) begin
            sk_rises++;
            if (!cs_o) cs_err++;
        end
        if (!cs_o) begin
            lead = 0; seen = 0;
        end else if (!sk_o && !seen) begin
            lead++;
        end else if (sk_o && !seen) begin
            seen = 1; lead_meas = lead;
        end
        prev_sk = sk_o;
        prev_di = di_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // watchdog
    initial begin
        #1500000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // launches a read and waits for done; returns cycles from start to done
    task automatic launch(input bit wide, input logic [7:0] a, output int lat);
        model_len = wide ? 11 : 9;
        rx_cmd    = '0;
        sk_rises  = 0;
        @(negedge clk);
        wide_addr_i = wide; addr_i = a; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o === 1'b1, "R8 busy after start", busy_o, 1);
        lat = 1;
        while (done_o !== 1'b1 && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset();
        chk(cs_o === 0 && sk_o === 0 && di_o === 0, "R9 lines low", {cs_o, sk_o, di_o}, 0);
        chk(busy_o === 0 && done_o === 0, "R9 busy/done low", {busy_o, done_o}, 0);
        chk(word_o === 16'h0, "R9 word zero", word_o, 0);
    endtask

    task automatic t_read(input bit wide, input logic [7:0] a);
        int lat;
        logic [7:0]  ea;
        logic [10:0] ecmd;
        ea   = wide ? a : {2'b00, a[5:0]};
        ecmd = wide ? {3'b110, a} : {2'b00, 3'b110, a[5:0]};
        launch(wide, a, lat);
        chk(done_o === 1'b1, "R6 done seen", done_o, 1);
        chk(rx_cmd === ecmd, "R1 command bits", rx_cmd, ecmd);
        chk(word_o === rom(ea), "R5 word assembled MSB first", word_o, rom(ea));
        chk(sk_rises == (wide ? 27 : 25), "R2 clock pulse count", sk_rises, wide ? 27 : 25);
        chk(cs_o === 0 && busy_o === 0, "R6 R8 cs and busy low at done", {cs_o, busy_o}, 0);
        @(negedge clk);
        chk(done_o === 0, "R6 done one cycle", done_o, 0);
        chk(word_o === rom(ea), "R6 word held", word_o, rom(ea));
    endtask

    task automatic t_line_timing();
        chk(per_bad == 0, "R4 high phase length", per_bad, 0);
        chk(stab_bad == 0, "R4 di stable while sk high", stab_bad, 0);
        chk(lead_meas == 2 * HALF, "R3 cs lead time", lead_meas, 2 * HALF);
        chk(cs_err == 0, "R3 cs high over sk pulses", cs_err, 0);
        chk(di_data_err == 0, "R5 di low in data phase", di_data_err, 0);
    endtask

    task automatic t_ignore_start();
        int lat;
        model_len = 11;
        rx_cmd = '0;
        sk_rises = 0;
        @(negedge clk);
        wide_addr_i = 1; addr_i = 8'h5A; start_i = 1;
        @(negedge clk);
        start_i = 0;
        repeat (HALF * 5) @(negedge clk);
        addr_i = 8'hC3; wide_addr_i = 0; start_i = 1;   // R7 stimulus mid-transfer
        @(negedge clk);
        start_i = 0;
        lat = 0;
        while (done_o !== 1'b1 && lat < 5000) begin @(negedge clk); lat++; end
        chk(rx_cmd === {3'b110, 8'h5A}, "R7 address kept", rx_cmd, {3'b110, 8'h5A});
        chk(word_o === rom(8'h5A), "R7 word of first request", word_o, rom(8'h5A));
        start_i = 1;                                     // R7 start during done cycle
        @(negedge clk);
        start_i = 0;
        repeat (HALF * 4) @(negedge clk);
        chk(busy_o === 0 && cs_o === 0, "R7 no extra transfer", {busy_o, cs_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_read(1, 8'hA5);
        t_read(1, 8'h00);
        t_read(0, 8'hFF);
        t_read(0, 8'h2B);
        t_read(1, 8'hFF);
        t_line_timing();
        t_ignore_start();
        finish_run();
    end
endmodule